// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the two ALU operand inputs of a five-stage in-order pipeline. For each of the two source register indices carried into the execute stage, it compares the index with the destination index of the instruction one stage ahead and with the destination index of the instruction two stages ahead. Each comparison counts only if that instruction's register-write flag is set.

From those comparisons the block forms a 2-bit select for each operand. The select steers a multiplexer that delivers one of three values: the register-file read value, the result held one stage ahead, or the result held two stages ahead. The block is purely combinational. It holds no state and needs no clock. The widths of register indices and data are parameters.

Stall detection for loads and the register file itself live elsewhere. The block only resolves which copy of a value is the newest valid one.

Top module: `fwd_unit`

## Requirements
- R1: Each operand select uses this encoding: 2'b00 passes the register-file value, 2'b10 passes the result one stage ahead (near stage), and 2'b01 passes the result two stages ahead (far stage). The operand output always equals the value that the select names.
- R2: Operand A selects the near stage (2'b10) when the near write flag is 1, the near destination index is non-zero, and that index equals the operand A source index.
- R3: Operand A selects the far stage (2'b01) when the far write flag is 1, the far destination index is non-zero and equals the operand A source index, and the near stage does not match operand A.
- R4: When both stages match the same source index, the near stage wins and the select is 2'b10.
- R5: A destination index of zero never causes forwarding. The select stays 2'b00 and the operand equals the register-file value.
- R6: A stage whose write flag is 0 never causes forwarding, whatever its destination index.
- R7: Operand B follows the same rules as operand A, using its own source index. The two operands are resolved independently, so one may take the near stage while the other takes the far stage.
- R8: The select value 2'b11 is never produced. An operand multiplexer given 2'b11 passes the register-file value.
- R9: Selects and operands respond to input changes in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | IDX_W | Operand A source register index (execute stage) |
| src_b_idx | input | IDX_W | Operand B source register index (execute stage) |
| rf_a_data | input | DATA_W | Register-file value read for operand A |
| rf_b_data | input | DATA_W | Register-file value read for operand B |
| near_we | input | 1 | Write flag of the instruction one stage ahead |
| near_dst | input | IDX_W | Destination index one stage ahead |
| near_res | input | DATA_W | Result one stage ahead |
| far_we | input | 1 | Write flag of the instruction two stages ahead |
| far_dst | input | IDX_W | Destination index two stages ahead |
| far_res | input | DATA_W | Result two stages ahead |
| sel_a | output | 2 | Operand A select code |
| sel_b | output | 2 | Operand B select code |
| op_a | output | DATA_W | Operand A delivered to the ALU |
| op_b | output | DATA_W | Operand B delivered to the ALU |

## Verification
The hardest case to reach is the one that splits the two operands: both stages write and match, one stage matches operand A and the other matches operand B, and a zero index or a cleared flag sits on one of the paths. Uniform random 5-bit indices almost never line up this way. The random stimulus therefore draws every index from the range 0 to 3. This makes matches, double writes and register-zero targets common, and the directed vectors pin the exact split and priority cases.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SEL_RF   = 2'b00,
    SEL_FAR  = 2'b01,
    SEL_NEAR = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic             near_we,
  input  logic [IDX_W-1:0] near_dst,
  input  logic             far_we,
  input  logic [IDX_W-1:0] far_dst,
  output fwd_sel_e         sel
);
  logic near_hit;
  logic far_hit;

  always_comb begin
    near_hit = near_we && (near_dst != '0) && (near_dst == src_idx);
    far_hit  = far_we && (far_dst != '0) && (far_dst == src_idx);
    if (near_hit)     sel = SEL_NEAR;
    else if (far_hit) sel = SEL_FAR;
    else              sel = SEL_RF;
  end
endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] near_val,
  input  logic [DATA_W-1:0] far_val,
  output logic [DATA_W-1:0] op
);
  always_comb begin
    case (sel)
      2'b10:   op = near_val;
      2'b01:   op = far_val;
      default: op = rf_val;
    endcase
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic              near_we,
  input  logic [IDX_W-1:0]  near_dst,
  input  logic [DATA_W-1:0] near_res,
  input  logic              far_we,
  input  logic [IDX_W-1:0]  far_dst,
  input  logic [DATA_W-1:0] far_res,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  localparam int NUM_OPS = 2;

  logic [IDX_W-1:0]  src_arr [NUM_OPS];
  logic [DATA_W-1:0] rf_arr  [NUM_OPS];
  logic [1:0]        sel_arr [NUM_OPS];
  logic [DATA_W-1:0] op_arr  [NUM_OPS];

  assign src_arr[0] = src_a_idx;
  assign src_arr[1] = src_b_idx;
  assign rf_arr[0]  = rf_a_data;
  assign rf_arr[1]  = rf_b_data;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_sel_e sel_e;

    fwd_match #(.IDX_W(IDX_W)) i_match (
      .src_idx (src_arr[g]),
      .near_we (near_we),
      .near_dst(near_dst),
      .far_we  (far_we),
      .far_dst (far_dst),
      .sel     (sel_e)
    );

    assign sel_arr[g] = sel_e;

    fwd_opmux #(.DATA_W(DATA_W)) i_mux (
      .sel     (sel_arr[g]),
      .rf_val  (rf_arr[g]),
      .near_val(near_res),
      .far_val (far_res),
      .op      (op_arr[g])
    );
  end

  assign sel_a = sel_arr[0];
  assign sel_b = sel_arr[1];
  assign op_a  = op_arr[0];
  assign op_b  = op_arr[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 32
) (
  input logic [IDX_W-1:0]  src_a_idx,
  input logic [IDX_W-1:0]  src_b_idx,
  input logic [DATA_W-1:0] rf_a_data,
  input logic [DATA_W-1:0] rf_b_data,
  input logic              near_we,
  input logic [IDX_W-1:0]  near_dst,
  input logic [DATA_W-1:0] near_res,
  input logic              far_we,
  input logic [IDX_W-1:0]  far_dst,
  input logic [DATA_W-1:0] far_res,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b
);
  always_comb begin
    // R8
    sel_a_legal_chk: assert (sel_a != 2'b11);
    // R8
    sel_b_legal_chk: assert (sel_b != 2'b11);
    // R1
    op_a_route_chk: assert ((sel_a == 2'b10) ? (op_a == near_res) :
                            (sel_a == 2'b01) ? (op_a == far_res) : (op_a == rf_a_data));
    // R1
    op_b_route_chk: assert ((sel_b == 2'b10) ? (op_b == near_res) :
                            (sel_b == 2'b01) ? (op_b == far_res) : (op_b == rf_b_data));
    // R5
    zero_dst_chk: assert (!((near_dst == '0) && (far_dst == '0)) ||
                          ((sel_a == 2'b00) && (sel_b == 2'b00)));
    // R6
    no_write_chk: assert (near_we || far_we || ((sel_a == 2'b00) && (sel_b == 2'b00)));
    // R4
    near_wins_chk: assert (!(near_we && (near_dst != '0) && (near_dst == src_a_idx)) ||
                           (sel_a == 2'b10));
  end
endmodule

bind fwd_unit fwd_unit_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_fwd_unit_chk (.*);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 32;

  logic clk;
  logic [IDX_W-1:0]  src_a_idx, src_b_idx, near_dst, far_dst;
  logic [DATA_W-1:0] rf_a_data, rf_b_data, near_res, far_res;
  logic              near_we, far_we;
  logic [1:0]        sel_a, sel_b;
  logic [DATA_W-1:0] op_a, op_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fwd_unit #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_fwd_unit (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [1:0] exp_sel(logic [IDX_W-1:0] src);
    if (near_we && near_dst != 0 && near_dst == src) return 2'b10;
    if (far_we && far_dst != 0 && far_dst == src)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] exp_op(logic [1:0] s, logic [DATA_W-1:0] rf);
    if (s == 2'b10) return near_res;
    if (s == 2'b01) return far_res;
    return rf;
  endfunction

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [IDX_W-1:0] sa, logic [IDX_W-1:0] sb,
                       logic nw, logic [IDX_W-1:0] nd, logic fw, logic [IDX_W-1:0] fd);
    @(negedge clk);
    src_a_idx = sa; src_b_idx = sb;
    near_we = nw; near_dst = nd; far_we = fw; far_dst = fd;
    rf_a_data = $urandom; rf_b_data = $urandom;
    near_res = $urandom; far_res = $urandom;
    #1;
  endtask

  task automatic verify(string req);
    logic [1:0] ea, eb;
    ea = exp_sel(src_a_idx);
    eb = exp_sel(src_b_idx);
    chk({req, " sel_a"}, DATA_W'(sel_a), DATA_W'(ea));
    chk({req, " sel_b"}, DATA_W'(sel_b), DATA_W'(eb));
    chk({req, " op_a"}, op_a, exp_op(ea, rf_a_data));
    chk({req, " op_b"}, op_b, exp_op(eb, rf_b_data));
  endtask

  task automatic expect_sel(string req, logic [1:0] ea, logic [1:0] eb);
    chk({req, " directed sel_a"}, DATA_W'(sel_a), DATA_W'(ea));
    chk({req, " directed sel_b"}, DATA_W'(sel_b), DATA_W'(eb));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    // R1: idle inputs pass register file values
    drive(0, 0, 0, 0, 0, 0);
    expect_sel("R1", 2'b00, 2'b00); verify("R1");
    // R2: back-to-back dependency on operand A
    drive(3, 7, 1, 3, 0, 0);
    expect_sel("R2", 2'b10, 2'b00); verify("R2");
    // R3: two-apart dependency on operand A
    drive(9, 2, 0, 0, 1, 9);
    expect_sel("R3", 2'b01, 2'b00); verify("R3");
    // R4: double write to same register, near wins
    drive(6, 6, 1, 6, 1, 6);
    expect_sel("R4", 2'b10, 2'b10); verify("R4");
    // R5: writes to register zero ignored
    drive(0, 0, 1, 0, 1, 0);
    expect_sel("R5", 2'b00, 2'b00); verify("R5");
    // R6: matching index but write flags cleared
    drive(4, 5, 0, 4, 0, 5);
    expect_sel("R6", 2'b00, 2'b00); verify("R6");
    // R6: near disabled, far still forwards
    drive(8, 8, 0, 8, 1, 8);
    expect_sel("R6", 2'b01, 2'b01); verify("R6");
    // R7: split operands near on A, far on B
    drive(11, 12, 1, 11, 1, 12);
    expect_sel("R7", 2'b10, 2'b01); verify("R7");
    // R7: operand B only, near
    drive(1, 13, 1, 13, 0, 0);
    expect_sel("R7", 2'b00, 2'b10); verify("R7");
    // R9: same-cycle response on a changed index
    drive(31, 31, 1, 31, 1, 31);
    expect_sel("R9", 2'b10, 2'b10); verify("R9");
    // R8: random mix, codes never 11, all against the model
    for (int i = 0; i < 600; i++) begin
      drive(IDX_W'($urandom_range(0, 3)), IDX_W'($urandom_range(0, 3)),
            1'($urandom), IDX_W'($urandom_range(0, 3)),
            1'($urandom), IDX_W'($urandom_range(0, 3)));
      verify("R8");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule